// File: doc/BRIEF.md
# Counter-set measurement unit

This block keeps a bank of event counters organised into four counter sets: basic, problem-state, crypto-activity and extended. Each set is in one of three states. A disabled set holds all its counters at zero. An enabled but inactive set freezes its counters. An enabled and active set counts its events. Software sets these states by loading a control word. The control word has an enable nibble and an activation nibble. Each set owns one bit position in both nibbles. A load is accepted only when every requested enable bit is also set in an authorization mask.

The event inputs are sampled every clock. The basic set counts clock cycles, instruction-retire strobes and four auxiliary strobes. The problem-state set counts the same six events, but only while the user-state input is high. The crypto and extended sets each count one strobe bit per counter. A registered read port takes a counter number and returns the value together with a condition code. Two pulse outputs report a change of the authorization mask and the loss of counter data. Counter data is lost when a set that was enabled has its authorization withdrawn.

Top module: `cmf_unit`

## Requirements
- R1: Counter numbers map to sets by range. Basic is 0..31, problem-state is 32..63, crypto is 64..127 and extended is 128..159. Each set has a code bit: extended bit 0, basic bit 1, problem-state bit 2, crypto bit 3. The set's enable bit is control bit 16 plus its code bit. Its activation bit is control bit 0 plus its code bit.
- R2: While a set's enable bit is clear, its counters are zero. Reading a counter of such a set returns condition code 3 with data zero.
- R3: While a set is enabled but not activated, its counters keep their values.
- R4: While the basic set is enabled and active, each clock adds one to the counters as follows. Counter 0 increments on every clock. Counter 1 increments when `evInstr` is high. Counters 2..5 increment when `auxEv[0..3]` are high.
- R5: Problem-state counters 32..37 count the same six events as basic counters 0..5, but only in cycles where `userState` is high.
- R6: Crypto counter 64+i counts `cryptoEv[i]` for i in 0..15. Extended counter 128+i counts `extEv[i]` for i in 0..31.
- R7: A control load whose enable nibble is not a subset of `authMask` is rejected. A rejected load pulses `ctlErr` for one cycle and leaves `ctlWord` unchanged.
- R8: Reading counters 6..31, 38..63, 80..127 or 160 and above returns condition code 2 with data zero. A read of a counter in an enabled set returns condition code 0 and the counter value.
- R9: Counters wrap modulo 2^CTR_W.
- R10: `authAlert` pulses in the cycle after `authMask` differs from its value at the previous clock.
- R11: An enabled set whose authorization bit is clear is forced disabled and deactivated at the next clock. `lossAlert` pulses in that same cycle.
- R12: Reset clears the control word, all counters, the read outputs and all alert and error outputs. Read results appear one clock after the address is presented. A load of all zeros disables every set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ctlWrEn | input | 1 | Load the control word this cycle |
| ctlWrData | input | 32 | Control word: enable nibble in bits 19:16, activation nibble in bits 3:0 |
| authMask | input | 4 | Authorization mask, one bit for each set code bit |
| evInstr | input | 1 | Instruction-retire strobe |
| userState | input | 1 | High while the processor runs in user state |
| auxEv | input | 4 | Auxiliary strobes for counters 2..5 and 34..37 |
| cryptoEv | input | 16 | Crypto-activity strobes |
| extEv | input | 32 | Extended strobes |
| rdAddr | input | ADDR_W | Counter number to read |
| rdData | output | CTR_W | Registered counter value |
| rdCc | output | 2 | Registered condition code: 0 valid, 2 no such counter, 3 set disabled |
| ctlWord | output | 32 | Current control word |
| ctlErr | output | 1 | Pulse: control load rejected |
| authAlert | output | 1 | Pulse: authorization mask changed |
| lossAlert | output | 1 | Pulse: counter data lost through revocation |

## Verification
A wrong set state shows up at the read port one clock after the faulty cycle. It appears as a condition code of 3 where 0 was due, or a counter that moves while it should be frozen. A reference model compares every output on every clock, so a slip in a counter is caught on the next read of that counter. The address sweeps are short, which keeps that read close to the slip. The authorization filter is checked through `ctlWord` and the error pulse. Revocation is checked through `lossAlert` and the counters going to zero in the cycle after the mask drops.

// File: rtl/cmf_pkg.sv
package cmf_pkg;

  localparam int unsigned NUM_SETS  = 4;
  localparam int unsigned EN_LSB    = 16;
  localparam int unsigned CTR_LIMIT = 160;

  // Set index: 0 basic, 1 problem-state, 2 crypto, 3 extended
  localparam int unsigned BASIC_BASE = 0;
  localparam int unsigned BASIC_LIVE = 6;
  localparam int unsigned USER_BASE  = 32;
  localparam int unsigned USER_LIVE  = 6;
  localparam int unsigned CRYP_BASE  = 64;
  localparam int unsigned CRYP_LIVE  = 16;
  localparam int unsigned EXT_BASE   = 128;
  localparam int unsigned EXT_LIVE   = 32;

  typedef struct packed {
    logic [NUM_SETS-1:0] setEn;
    logic [NUM_SETS-1:0] setRun;
  } setCtl_t;

  // Bit position of a set inside the enable and activation nibbles
  function automatic int unsigned codeBit(input int unsigned setIdx);
    case (setIdx)
      0:       codeBit = 1;
      1:       codeBit = 2;
      2:       codeBit = 3;
      default: codeBit = 0;
    endcase
  endfunction

endpackage

// File: rtl/cmf_ctrl.sv
module cmf_ctrl
  import cmf_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          ctlWrEn,
  input  logic [31:0]   ctlWrData,
  input  logic [3:0]    authMask,
  output logic [31:0]   ctlWord,
  output logic          ctlErr,
  output logic          authAlert,
  output logic          lossAlert,
  output setCtl_t       setCtl
);

  logic [3:0] enNib, actNib, authPrev;
  logic [3:0] wrEnNib, revoke;
  logic       accept;
  logic       unusedBits;

  assign wrEnNib    = ctlWrData[EN_LSB+3:EN_LSB];
  assign accept     = ctlWrEn && ((wrEnNib & ~authMask) == 4'b0);
  assign revoke     = enNib & ~authMask;
  assign unusedBits = ^{ctlWrData[31:20], ctlWrData[15:4]};
  assign ctlWord    = {12'b0, enNib, 12'b0, actNib};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enNib     <= '0;
      actNib    <= '0;
      authPrev  <= '0;
      ctlErr    <= 1'b0;
      authAlert <= 1'b0;
      lossAlert <= 1'b0;
    end else begin
      authPrev  <= authMask;
      authAlert <= (authMask != authPrev);
      lossAlert <= |revoke;
      ctlErr    <= ctlWrEn && !accept;
      if (accept) begin
        enNib  <= wrEnNib;
        actNib <= ctlWrData[3:0];
      end else begin
        enNib  <= enNib & ~revoke;
        actNib <= actNib & ~revoke;
      end
    end
  end

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_map
    assign setCtl.setEn[s]  = enNib[codeBit(s)];
    assign setCtl.setRun[s] = actNib[codeBit(s)];
  end

  AST_REJECT_KEEPS_WORD: assert property (@(posedge clk) disable iff (!rstN)
    (ctlWrEn && ((ctlWrData[19:16] & ~authMask) != 4'b0) &&
     ((ctlWord[19:16] & ~authMask) == 4'b0))
    |=> (ctlErr && ctlWord == $past(ctlWord))); // R7

  AST_ENABLE_AUTHORIZED: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((ctlWord[19:16] & ~$past(authMask)) == 4'b0)); // R11

  AST_AUTH_CHANGE_ALERT: assert property (@(posedge clk) disable iff (!rstN)
    (authMask != $past(authMask)) |=> authAlert); // R10

endmodule

// File: rtl/cmf_bank.sv
module cmf_bank #(
  parameter int unsigned CTR_W = 64,
  parameter int unsigned NCTR  = 6
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       en,
  input  logic                       run,
  input  logic [NCTR-1:0]            ev,
  output logic [NCTR-1:0][CTR_W-1:0] cnt
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else begin
      for (int i = 0; i < int'(NCTR); i++) begin
        if (!en)
          cnt[i] <= '0;
        else if (run && ev[i])
          cnt[i] <= cnt[i] + 1'b1;
      end
    end
  end

  AST_CLEAR_WHEN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !en |=> (cnt[0] == '0)); // R2

  AST_HOLD_PARKED: assert property (@(posedge clk) disable iff (!rstN)
    (en && !run) |=> $stable(cnt[NCTR-1])); // R3

endmodule

// File: rtl/cmf_datapath.sv
module cmf_datapath
  import cmf_pkg::*;
#(
  parameter int unsigned CTR_W  = 64,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  setCtl_t           setCtl,
  input  logic              evInstr,
  input  logic              userState,
  input  logic [3:0]        auxEv,
  input  logic [15:0]       cryptoEv,
  input  logic [31:0]       extEv,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [CTR_W-1:0]  rdData,
  output logic [1:0]        rdCc
);

  logic [BASIC_LIVE-1:0][CTR_W-1:0] basicCnt;
  logic [USER_LIVE-1:0][CTR_W-1:0]  userCnt;
  logic [CRYP_LIVE-1:0][CTR_W-1:0]  crypCnt;
  logic [EXT_LIVE-1:0][CTR_W-1:0]   extCnt;
  logic [BASIC_LIVE-1:0]            basicEv;
  logic [USER_LIVE-1:0]             userEv;

  assign basicEv = {auxEv, evInstr, 1'b1};
  assign userEv  = basicEv & {USER_LIVE{userState}};

  cmf_bank #(.CTR_W(CTR_W), .NCTR(BASIC_LIVE)) u_basic (
    .clk(clk), .rstN(rstN), .en(setCtl.setEn[0]), .run(setCtl.setRun[0]),
    .ev(basicEv), .cnt(basicCnt));
  cmf_bank #(.CTR_W(CTR_W), .NCTR(USER_LIVE)) u_user (
    .clk(clk), .rstN(rstN), .en(setCtl.setEn[1]), .run(setCtl.setRun[1]),
    .ev(userEv), .cnt(userCnt));
  cmf_bank #(.CTR_W(CTR_W), .NCTR(CRYP_LIVE)) u_cryp (
    .clk(clk), .rstN(rstN), .en(setCtl.setEn[2]), .run(setCtl.setRun[2]),
    .ev(cryptoEv), .cnt(crypCnt));
  cmf_bank #(.CTR_W(CTR_W), .NCTR(EXT_LIVE)) u_ext (
    .clk(clk), .rstN(rstN), .en(setCtl.setEn[3]), .run(setCtl.setRun[3]),
    .ev(extEv), .cnt(extCnt));

  logic [31:0]      addrW;
  logic [CTR_W-1:0] selVal;
  logic [1:0]       selCc;
  logic             live;
  logic             liveEn;

  assign addrW = 32'(rdAddr);

  always_comb begin
    selVal = '0;
    live   = 1'b0;
    liveEn = 1'b0;
    for (int i = 0; i < int'(BASIC_LIVE); i++)
      if (addrW == BASIC_BASE + i) begin
        selVal = basicCnt[i]; live = 1'b1; liveEn = setCtl.setEn[0];
      end
    for (int i = 0; i < int'(USER_LIVE); i++)
      if (addrW == USER_BASE + i) begin
        selVal = userCnt[i]; live = 1'b1; liveEn = setCtl.setEn[1];
      end
    for (int i = 0; i < int'(CRYP_LIVE); i++)
      if (addrW == CRYP_BASE + i) begin
        selVal = crypCnt[i]; live = 1'b1; liveEn = setCtl.setEn[2];
      end
    for (int i = 0; i < int'(EXT_LIVE); i++)
      if (addrW == EXT_BASE + i) begin
        selVal = extCnt[i]; live = 1'b1; liveEn = setCtl.setEn[3];
      end
    if (!live) begin
      selCc  = 2'd2;
      selVal = '0;
    end else if (!liveEn) begin
      selCc  = 2'd3;
      selVal = '0;
    end else begin
      selCc  = 2'd0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData <= '0;
      rdCc   <= 2'd0;
    end else begin
      rdData <= selVal;
      rdCc   <= selCc;
    end
  end

  AST_OUT_OF_RANGE_CC: assert property (@(posedge clk) disable iff (!rstN)
    (addrW >= CTR_LIMIT) |=> (rdCc == 2'd2 && rdData == '0)); // R8

  AST_DISABLED_SET_CC: assert property (@(posedge clk) disable iff (!rstN)
    (!setCtl.setEn[3] && addrW >= EXT_BASE && addrW < CTR_LIMIT)
    |=> (rdCc == 2'd3)); // R2

endmodule

// File: rtl/cmf_unit.sv
module cmf_unit
  import cmf_pkg::*;
#(
  parameter int unsigned CTR_W  = 64,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctlWrEn,
  input  logic [31:0]       ctlWrData,
  input  logic [3:0]        authMask,
  input  logic              evInstr,
  input  logic              userState,
  input  logic [3:0]        auxEv,
  input  logic [15:0]       cryptoEv,
  input  logic [31:0]       extEv,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [CTR_W-1:0]  rdData,
  output logic [1:0]        rdCc,
  output logic [31:0]       ctlWord,
  output logic              ctlErr,
  output logic              authAlert,
  output logic              lossAlert
);

  setCtl_t setCtl;

  cmf_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .ctlWrEn(ctlWrEn), .ctlWrData(ctlWrData),
    .authMask(authMask), .ctlWord(ctlWord), .ctlErr(ctlErr),
    .authAlert(authAlert), .lossAlert(lossAlert), .setCtl(setCtl));

  cmf_datapath #(.CTR_W(CTR_W), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .setCtl(setCtl), .evInstr(evInstr),
    .userState(userState), .auxEv(auxEv), .cryptoEv(cryptoEv),
    .extEv(extEv), .rdAddr(rdAddr), .rdData(rdData), .rdCc(rdCc));

endmodule

// File: tb/sim_cmf_unit.sv
module sim_cmf_unit;

  localparam int CLK_PERIOD = 10;
  localparam int CTR_W      = 8;
  localparam int ADDR_W     = 8;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              ctlWrEn = 1'b0;
  logic [31:0]       ctlWrData = '0;
  logic [3:0]        authMask = '0;
  logic              evInstr = 1'b0;
  logic              userState = 1'b0;
  logic [3:0]        auxEv = '0;
  logic [15:0]       cryptoEv = '0;
  logic [31:0]       extEv = '0;
  logic [ADDR_W-1:0] rdAddr = '0;
  logic [CTR_W-1:0]  rdData;
  logic [1:0]        rdCc;
  logic [31:0]       ctlWord;
  logic              ctlErr, authAlert, lossAlert;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmf_unit #(.CTR_W(CTR_W), .ADDR_W(ADDR_W)) u0 (
    .clk(clk), .rstN(rstN), .ctlWrEn(ctlWrEn), .ctlWrData(ctlWrData),
    .authMask(authMask), .evInstr(evInstr), .userState(userState),
    .auxEv(auxEv), .cryptoEv(cryptoEv), .extEv(extEv), .rdAddr(rdAddr),
    .rdData(rdData), .rdCc(rdCc), .ctlWord(ctlWord), .ctlErr(ctlErr),
    .authAlert(authAlert), .lossAlert(lossAlert));

  int    nChecks = 0;
  int    nFails  = 0;
  int    cycles  = 0;
  string phase   = "R12 reset";

  // ---------------- reference model ----------------
  logic [CTR_W-1:0] mCnt [0:159];
  logic [31:0]      mCtl;
  logic [3:0]       mAuthPrev;
  logic [CTR_W-1:0] eData;
  logic [1:0]       eCc;
  logic             eErr, eAuth, eLoss;
  string            eTag;

  // set of a counter number: -1 none, 0 basic, 1 user, 2 crypto, 3 ext
  function automatic int setOf(int n);
    if (n < 6) return 0;
    if (n >= 32 && n < 38) return 1;
    if (n >= 64 && n < 80) return 2;
    if (n >= 128 && n < 160) return 3;
    return -1;
  endfunction

  function automatic int bitOf(int s);
    case (s)
      0: return 1;
      1: return 2;
      2: return 3;
      default: return 0;
    endcase
  endfunction

  function automatic bit evOf(int n);
    bit base;
    int k;
    k = (n >= 32 && n < 38) ? n - 32 : n;
    if (n >= 64 && n < 80) return cryptoEv[n-64];
    if (n >= 128) return extEv[n-128];
    case (k)
      0: base = 1'b1;
      1: base = evInstr;
      default: base = auxEv[k-2];
    endcase
    if (n >= 32) return base && userState;
    return base;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int n = 0; n < 160; n++) mCnt[n] = '0;
      mCtl = '0; mAuthPrev = '0;
      eData = '0; eCc = 2'd0; eErr = 1'b0; eAuth = 1'b0; eLoss = 1'b0;
      eTag = "R12";
    end else begin
      int s;
      logic [3:0] en, act, rev;
      en  = mCtl[19:16];
      act = mCtl[3:0];
      s   = setOf(int'(rdAddr));
      if (s < 0) begin
        eCc = 2'd2; eData = '0; eTag = "R8";
      end else if (!en[bitOf(s)]) begin
        eCc = 2'd3; eData = '0; eTag = "R2";
      end else begin
        eCc = 2'd0; eData = mCnt[rdAddr];
        eTag = (s == 0) ? "R4" : (s == 1) ? "R5" : "R6";
      end
      for (int n = 0; n < 160; n++) begin
        int t;
        t = setOf(n);
        if (t >= 0) begin
          if (!en[bitOf(t)]) mCnt[n] = '0;
          else if (act[bitOf(t)] && evOf(n)) mCnt[n] = mCnt[n] + 1'b1;
        end
      end
      rev   = en & ~authMask;
      eLoss = |rev;
      eAuth = (authMask != mAuthPrev);
      mAuthPrev = authMask;
      eErr  = 1'b0;
      if (ctlWrEn && ((ctlWrData[19:16] & ~authMask) == 4'b0))
        mCtl = ctlWrData & 32'h000F_000F;
      else begin
        if (ctlWrEn) eErr = 1'b1;
        mCtl = mCtl & ~{12'b0, rev, 12'b0, rev};
      end
    end
  end

  // ---------------- checking ----------------
  task automatic chk(string req, string what, longint act, longint exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s [%s] %s: actual %0h expected %0h (t=%0t)",
               req, phase, what, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #(CLK_PERIOD/4);
    cycles++;
    chk(eTag, "rdData", longint'(rdData), longint'(eData));
    chk(eTag, "rdCc", longint'(rdCc), longint'(eCc));
    chk("R7", "ctlWord", longint'(ctlWord), longint'(mCtl));
    chk("R7", "ctlErr", longint'(ctlErr), longint'(eErr));
    chk("R10", "authAlert", longint'(authAlert), longint'(eAuth));
    chk("R11", "lossAlert", longint'(lossAlert), longint'(eLoss));
    ctlWrEn = 1'b0;
  endtask

  task automatic randEv();
    evInstr   = 1'($urandom);
    userState = 1'($urandom);
    auxEv     = 4'($urandom);
    cryptoEv  = 16'($urandom);
    extEv     = $urandom;
  endtask

  task automatic load(logic [31:0] w);
    ctlWrEn = 1'b1; ctlWrData = w;
    step();
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
  end

  initial begin
    // R12: reset values
    repeat (3) step();
    #(CLK_PERIOD/4);
    rstN = 1'b1;
    step(); step();

    // R10: authorization change alert; R1, R4: basic set by its code bit
    phase = "R1 R4 basic";
    authMask = 4'hF;
    step();
    load(32'h0002_0002);
    for (int c = 0; c < 40; c++) begin
      randEv(); rdAddr = 8'(c % 6); step();
    end
    rdAddr = 8'd128; step();  // R1: extended set still disabled

    // R5, R6, R8: all sets active, sweep every number
    phase = "R5 R6 R8 sweep";
    load(32'h000F_000F);
    for (int a = 0; a < 256; a++) begin
      randEv(); rdAddr = 8'(a); step();
    end

    // R3: crypto enabled but inactive
    phase = "R3 hold";
    load(32'h000F_0007);
    for (int c = 0; c < 32; c++) begin
      randEv(); rdAddr = 8'(64 + (c % 16)); step();
    end

    // R11: revoke crypto while enabled
    phase = "R11 revoke";
    authMask = 4'b0111;
    step();
    rdAddr = 8'd70; step(); step();

    // R7: unauthorized load rejected
    phase = "R7 reject";
    load(32'h000F_000F);
    step();
    load(32'h0001_0001);
    rdAddr = 8'd130; randEv(); step();

    // R12, R2: all-zero load disables every set
    phase = "R2 R12 zero load";
    load(32'h0000_0000);
    for (int a = 0; a < 160; a += 9) begin
      randEv(); rdAddr = 8'(a); step();
    end

    // R9: wrap of counter 0
    phase = "R9 wrap";
    load(32'h0002_0002);
    rdAddr = 8'd0;
    for (int c = 0; c < 300; c++) step();

    summary();
  end

endmodule